// File: doc/BRIEF.md
# Double-Edge PWM Channel with Restart-Aligned Shadow Loading

This block drives six pulse-width modulated outputs from one shared time base. A prescaler divides the clock, and each prescaler tick advances a 16-bit counter from zero up to a programmed period. Each output has a rising compare value and a falling compare value of its own. The output goes high after the counter reaches the rising value and goes low after it reaches the falling value, so both edges of every pulse can be placed anywhere in the period.

Software presents the period and the twelve compare values on live inputs. The time base never uses those inputs directly. They are copied into shadow registers all together, and only at a counter restart for which a transfer was asked for. A half-written set of values therefore never reaches the outputs.

The counter can loop forever (continuous mode) or stop once at the period value (run-once mode). Several channels can be chained. A master reports every restart on `sync_out_o` and reports restarts that carried a shadow load on `trans_en_out_o`. A slave restarts on `sync_in_i` and takes its shadow load from `trans_en_in_i`. Each output can also raise a one-cycle interrupt pulse on its rising edge and on its falling edge.

Top module: `pwm_sync_shadow`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, all outputs are low and `cnt_o` is 0. The counter stays stopped until a start or an accepted sync arrives.
- R2: While running, the counter advances by one every prescale_i+1 clock cycles, from 0 up to the shadow period inclusive. In continuous mode it wraps to 0 after the period. A restart also clears the prescaler.
- R3: `pwm_o[i]` is a register. It goes high the cycle after the counter equals the shadow rising value of output i, and goes low the cycle after the counter equals the shadow falling value. When the two values are equal the output stays low.
- R4: Changing `period_i`, `rise_i` or `fall_i` has no effect on the counter or the outputs until a shadow transfer takes place. A transfer happens only at a restart, and it copies the period and all compare values together.
- R5: A `xfer_req_i` pulse leaves a request pending. In master mode (`slave_i`=0) the next restart consumes it and performs the transfer. Later restarts perform no transfer until the next request.
- R6: `sync_out_o` is high for exactly one cycle after every restart. A restart is a `start_i` pulse, a continuous-mode wrap, or an accepted `sync_in_i`. In the cycle `sync_out_o` is high, `cnt_o` is 0.
- R7: `trans_en_out_o` is high in the same cycle as `sync_out_o` when that restart performed a shadow transfer, and is low at every other time.
- R8: In run-once mode (`once_i`=1) the counter stops at the period value, all outputs are driven low, and no further `sync_out_o` pulse occurs until the next `start_i`.
- R9: With `slave_i`=1, a `sync_in_i` pulse restarts the counter and the prescaler. With `slave_i`=0, `sync_in_i` is ignored.
- R10: With `slave_i`=1, a restart transfers the shadows if and only if `trans_en_in_i` is high in the same cycle. A pending local request has no effect in this mode.
- R11: When `irq_rise_en_i[i]` is set, `irq_rise_o[i]` pulses for one cycle in the first cycle that `pwm_o[i]` is high. `irq_fall_o[i]` behaves the same way for the first low cycle and is gated by `irq_fall_en_i[i]`. A disabled interrupt never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Restart pulse from software |
| once_i | input | 1 | 1 = run-once mode, 0 = continuous |
| slave_i | input | 1 | 1 = restart on external sync |
| prescale_i | input | PRE_W | Prescale divider minus one |
| period_i | input | 16 | Period value for the shadow |
| rise_i | input | NUM_OUT x 16 | Rising compare value per output |
| fall_i | input | NUM_OUT x 16 | Falling compare value per output |
| xfer_req_i | input | 1 | Pulse requesting a shadow transfer |
| sync_in_i | input | 1 | External restart pulse (slave mode) |
| trans_en_in_i | input | 1 | External transfer qualifier (slave mode) |
| irq_rise_en_i | input | NUM_OUT | Rising-edge interrupt enables |
| irq_fall_en_i | input | NUM_OUT | Falling-edge interrupt enables |
| pwm_o | output | NUM_OUT | PWM outputs |
| irq_rise_o | output | NUM_OUT | Rising-edge interrupt pulses |
| irq_fall_o | output | NUM_OUT | Falling-edge interrupt pulses |
| cnt_o | output | 16 | Current counter value |
| sync_out_o | output | 1 | Restart pulse to slaves |
| trans_en_out_o | output | 1 | Transfer-at-restart pulse to slaves |

## Verification
The assertions check the following on every cycle:
- the counter never passes the shadow period and only moves on a prescaler tick or a restart;
- the shadow registers change only on a load;
- a transfer pulse never appears without a sync pulse;
- equal compare values never let an output rise;
- interrupt pulses coincide with an actual output edge;
- a stopped counter keeps every output low.

The directed scenarios are needed to show the rest:
- exact waveform shapes and the prescaler's timing;
- that live writes without a request change nothing;
- that a request is consumed exactly once;
- that run-once stops where it should;
- how slave mode picks its restart source and its transfer source.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    localparam int unsigned CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    // Compare pair for one output: level rises at .rise, falls at .fall
    typedef struct packed {
        cnt_t rise;
        cnt_t fall;
    } edge_pair_t;

    // Next level of one output given the count it is looking at.
    // Falling match wins, so equal values keep the output low.
    function automatic logic edge_level(cnt_t c, edge_pair_t p, logic cur);
        if (c == p.fall) return 1'b0;
        if (c == p.rise) return 1'b1;
        return cur;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_sync_pkg::*;
#(
    parameter int unsigned PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] prescale_i,
    input  cnt_t             per_sh_i,
    input  logic             once_i,
    input  logic             start_i,
    input  logic             sync_ext_i,
    output cnt_t             cnt_o,
    output logic             run_o,
    output logic             restart_o
);

    logic [PRE_W-1:0] pre_q;
    cnt_t             cnt_q;
    logic             run_q;
    logic             tick;
    logic             at_end;

    assign tick      = run_q && (pre_q >= prescale_i);
    assign at_end    = (cnt_q == per_sh_i);
    assign restart_o = start_i || sync_ext_i || (tick && at_end && !once_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (restart_o) begin
            pre_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (tick) begin
            pre_q <= '0;
            if (at_end) run_q <= 1'b0;      // run-once end, count held
            else        cnt_q <= cnt_q + 1'b1;
        end else if (run_q) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
    assign run_o = run_q;

    // R2: count never passes the period held in the shadow bank
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= per_sh_i);

    // R2: without tick or restart the counter holds its value
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart_o) |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
    import pwm_sync_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  cnt_t                     per_i,
    input  edge_pair_t [NUM_OUT-1:0] edges_i,
    input  logic                     req_set_i,
    input  logic                     slave_i,
    input  logic                     trans_en_in_i,
    input  logic                     restart_i,
    output cnt_t                     per_sh_o,
    output edge_pair_t [NUM_OUT-1:0] edges_sh_o,
    output logic                     load_o
);

    logic                     req_q;
    cnt_t                     per_q;
    edge_pair_t [NUM_OUT-1:0] edges_q;

    assign load_o = restart_i && (slave_i ? trans_en_in_i : req_q);

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= (req_q && !(restart_i && !slave_i)) || req_set_i;
    end

    always_ff @(posedge clk) begin
        if (rst)         per_q <= '0;
        else if (load_o) per_q <= per_i;
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_sh
        always_ff @(posedge clk) begin
            if (rst)         edges_q[g] <= '0;
            else if (load_o) edges_q[g] <= edges_i[g];
        end
    end

    assign per_sh_o   = per_q;
    assign edges_sh_o = edges_q;

    // R4: shadows move only on a transfer
    assert_shadow_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !load_o |=> ($stable(per_q) && $stable(edges_q)));

endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan
    import pwm_sync_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    input  cnt_t       cnt_i,
    input  edge_pair_t pair_i,
    input  logic       irq_rise_en_i,
    input  logic       irq_fall_en_i,
    output logic       out_o,
    output logic       irq_rise_o,
    output logic       irq_fall_o
);

    logic out_q, ir_q, if_q, nxt;

    assign nxt = run_i ? edge_level(cnt_i, pair_i, out_q) : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
            ir_q  <= 1'b0;
            if_q  <= 1'b0;
        end else begin
            out_q <= nxt;
            ir_q  <= irq_rise_en_i && !out_q && nxt;
            if_q  <= irq_fall_en_i && out_q && !nxt;
        end
    end

    assign out_o      = out_q;
    assign irq_rise_o = ir_q;
    assign irq_fall_o = if_q;

    // R3: equal compare values never let a low output rise
    assert_equal_low_R3: assert property (@(posedge clk) disable iff (rst)
        (pair_i.rise == pair_i.fall && !out_q) |=> !out_q);

    // R11: interrupt pulses line up with real output edges
    assert_irq_rise_edge_R11: assert property (@(posedge clk) disable iff (rst)
        ir_q |-> (out_q && !$past(out_q)));
    assert_irq_fall_edge_R11: assert property (@(posedge clk) disable iff (rst)
        if_q |-> (!out_q && $past(out_q)));

endmodule

// File: rtl/pwm_sync_shadow.sv
module pwm_sync_shadow
    import pwm_sync_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6,
    parameter int unsigned PRE_W   = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_i,
    input  logic                          once_i,
    input  logic                          slave_i,
    input  logic [PRE_W-1:0]              prescale_i,
    input  logic [CNT_W-1:0]              period_i,
    input  logic [NUM_OUT-1:0][CNT_W-1:0] rise_i,
    input  logic [NUM_OUT-1:0][CNT_W-1:0] fall_i,
    input  logic                          xfer_req_i,
    input  logic                          sync_in_i,
    input  logic                          trans_en_in_i,
    input  logic [NUM_OUT-1:0]            irq_rise_en_i,
    input  logic [NUM_OUT-1:0]            irq_fall_en_i,
    output logic [NUM_OUT-1:0]            pwm_o,
    output logic [NUM_OUT-1:0]            irq_rise_o,
    output logic [NUM_OUT-1:0]            irq_fall_o,
    output logic [CNT_W-1:0]              cnt_o,
    output logic                          sync_out_o,
    output logic                          trans_en_out_o
);

    cnt_t                     cnt, per_sh;
    logic                     running, restart, load;
    edge_pair_t [NUM_OUT-1:0] edges_in, edges_sh;
    logic                     sync_q, trans_q;

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_pack
        assign edges_in[g] = '{rise: rise_i[g], fall: fall_i[g]};
    end

    pwm_timebase #(.PRE_W(PRE_W)) u_tb (
        .clk        (clk),
        .rst        (rst),
        .prescale_i (prescale_i),
        .per_sh_i   (per_sh),
        .once_i     (once_i),
        .start_i    (start_i),
        .sync_ext_i (slave_i && sync_in_i),
        .cnt_o      (cnt),
        .run_o      (running),
        .restart_o  (restart)
    );

    pwm_shadow_bank #(.NUM_OUT(NUM_OUT)) u_sh (
        .clk           (clk),
        .rst           (rst),
        .per_i         (period_i),
        .edges_i       (edges_in),
        .req_set_i     (xfer_req_i),
        .slave_i       (slave_i),
        .trans_en_in_i (trans_en_in_i),
        .restart_i     (restart),
        .per_sh_o      (per_sh),
        .edges_sh_o    (edges_sh),
        .load_o        (load)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_ch
        pwm_edge_chan u_ch (
            .clk           (clk),
            .rst           (rst),
            .run_i         (running),
            .cnt_i         (cnt),
            .pair_i        (edges_sh[g]),
            .irq_rise_en_i (irq_rise_en_i[g]),
            .irq_fall_en_i (irq_fall_en_i[g]),
            .out_o         (pwm_o[g]),
            .irq_rise_o    (irq_rise_o[g]),
            .irq_fall_o    (irq_fall_o[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 1'b0;
            trans_q <= 1'b0;
        end else begin
            sync_q  <= restart;
            trans_q <= load;
        end
    end

    assign sync_out_o     = sync_q;
    assign trans_en_out_o = trans_q;
    assign cnt_o          = cnt;

    // R7: a transfer report always rides on a sync pulse
    assert_trans_with_sync_R7: assert property (@(posedge clk) disable iff (rst)
        trans_q |-> sync_q);

    // R6: counter reads zero whenever the sync pulse is out
    assert_sync_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
        sync_q |-> (cnt == '0));

    // R8: a counter stopped for two cycles leaves every output low
    assert_stopped_low_R8: assert property (@(posedge clk) disable iff (rst)
        (!running && !$past(running)) |-> (pwm_o == '0));

endmodule

// File: tb/pwm_sync_shadow_tb_top.sv
`timescale 1ns/1ps
module pwm_sync_shadow_tb_top;
    import pwm_sync_pkg::*;

    localparam int N = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                  rst, start_i, once_i, slave_i;
    logic [15:0]           prescale_i;
    logic [CNT_W-1:0]      period_i;
    logic [N-1:0][CNT_W-1:0] rise_i, fall_i;
    logic                  xfer_req_i, sync_in_i, trans_en_in_i;
    logic [N-1:0]          irq_rise_en_i, irq_fall_en_i;
    logic [N-1:0]          pwm_o, irq_rise_o, irq_fall_o;
    logic [CNT_W-1:0]      cnt_o;
    logic                  sync_out_o, trans_en_out_o;

    int checks = 0;
    int errors = 0;

    pwm_sync_shadow #(.NUM_OUT(N), .PRE_W(16)) dut_i (.*);

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic set_edge(int i, int r, int f);
        rise_i[i] = CNT_W'(r);
        fall_i[i] = CNT_W'(f);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_req();
        @(negedge clk) xfer_req_i = 1'b1;
        @(negedge clk) xfer_req_i = 1'b0;
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!sync_out_o);
    endtask

    task automatic interval(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!sync_out_o);
    endtask

    task automatic wait_cnt(int v);
        do @(negedge clk); while (cnt_o != CNT_W'(v));
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pwm after reset", int'(pwm_o), 0);
        chk("R1 cnt after reset", int'(cnt_o), 0);
        chk("R1 sync after reset", int'(sync_out_o), 0);
        chk("R1 irq after reset", int'(irq_rise_o | irq_fall_o), 0);
        repeat (4) @(negedge clk);
        chk("R1 counter stays stopped", int'(cnt_o), 0);
    endtask

    // R2 R3 R5 R6 R7 R11: continuous run, period 9, no prescale
    task automatic t_continuous();
        int rc[N];
        int fc[N];
        logic [N-1:0] exp;
        int pc;
        period_i = 16'd9;
        for (int i = 0; i < 5; i++) set_edge(i, i + 1, i + 5);
        set_edge(5, 3, 3);
        irq_rise_en_i = '1;
        irq_fall_en_i = '1;
        pulse_req();
        pulse_start();
        chk("R6 sync after start", int'(sync_out_o), 1);
        chk("R7 trans after requested start", int'(trans_en_out_o), 1);
        chk("R2 cnt at start", int'(cnt_o), 0);
        for (int i = 0; i < N; i++) begin rc[i] = 0; fc[i] = 0; end
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            chk("R2 count sequence", int'(cnt_o), k % 10);
            pc = (k - 1) % 10;
            for (int i = 0; i < N; i++)
                exp[i] = (int'(rise_i[i]) < int'(fall_i[i])) &&
                         pc >= int'(rise_i[i]) && pc < int'(fall_i[i]);
            chk("R3 pwm waveform", int'(pwm_o), int'(exp));
            for (int i = 0; i < N; i++) begin
                rc[i] += int'(irq_rise_o[i]);
                fc[i] += int'(irq_fall_o[i]);
            end
            if (k == 10) begin
                chk("R6 sync at wrap", int'(sync_out_o), 1);
                chk("R5 request consumed once", int'(trans_en_out_o), 0);
            end
        end
        for (int i = 0; i < 5; i++) begin
            chk("R11 rise irq count", rc[i], 2);
            chk("R11 fall irq count", fc[i], 2);
        end
        chk("R3 equal values no rise irq", rc[5], 0);
    endtask

    // R4 R5 R7: live writes ignored until requested
    task automatic t_shadow();
        int n;
        period_i = 16'd4;
        set_edge(0, 1, 3);
        set_edge(1, 2, 7);
        for (int i = 2; i < 5; i++) set_edge(i, 0, 2);
        set_edge(5, 2, 2);
        wait_sync();
        chk("R7 no trans without request", int'(trans_en_out_o), 0);
        interval(n);
        chk("R4 old period kept", n, 10);
        pulse_req();
        wait_sync();
        chk("R7 trans after request", int'(trans_en_out_o), 1);
        interval(n);
        chk("R4 new period after transfer", n, 5);
    endtask

    // R2: prescaler divides by prescale+1
    task automatic t_prescale();
        prescale_i = 16'd2;
        wait_sync();
        for (int j = 1; j < 15; j++) begin
            @(negedge clk);
            chk("R2 prescaled count", int'(cnt_o), j / 3);
        end
        @(negedge clk);
        chk("R2 prescaled wrap", int'(sync_out_o), 1);
        prescale_i = 16'd0;
    endtask

    // R8: run-once stops at period, forces outputs low
    task automatic t_once();
        int syncs = 0;
        int seen1 = 0;
        once_i = 1'b1;
        pulse_start();
        chk("R8 sync on start", int'(sync_out_o), 1);
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (pwm_o[1]) seen1 = 1;
            if (sync_out_o) syncs++;
        end
        chk("R8 output ran", seen1, 1);
        chk("R8 counter held at period", int'(cnt_o), 4);
        chk("R8 outputs low when stopped", int'(pwm_o), 0);
        chk("R8 no sync while stopped", syncs, 0);
        pulse_start();
        chk("R8 restart sync", int'(sync_out_o), 1);
        chk("R8 restart count", int'(cnt_o), 0);
        once_i = 1'b0;
    endtask

    // R9 R10: slave mode
    task automatic t_slave();
        int n;
        slave_i = 1'b1;
        pulse_req();
        wait_cnt(2);
        sync_in_i = 1'b1;
        @(negedge clk) sync_in_i = 1'b0;
        chk("R9 sync_in resets counter", int'(cnt_o), 0);
        chk("R9 sync_in gives sync_out", int'(sync_out_o), 1);
        chk("R10 local request ignored", int'(trans_en_out_o), 0);
        period_i = 16'd6;
        wait_cnt(1);
        sync_in_i = 1'b1;
        trans_en_in_i = 1'b1;
        @(negedge clk) begin sync_in_i = 1'b0; trans_en_in_i = 1'b0; end
        chk("R10 external transfer", int'(trans_en_out_o), 1);
        interval(n);
        chk("R10 period from external transfer", n, 7);
        slave_i = 1'b0;
        wait_cnt(2);
        sync_in_i = 1'b1;
        @(negedge clk) sync_in_i = 1'b0;
        chk("R9 sync_in ignored as master", int'(cnt_o), 3);
        chk("R9 no sync_out as master", int'(sync_out_o), 0);
    endtask

    // R11: disabled interrupts stay quiet
    task automatic t_irq_off();
        int pulses = 0;
        int tog = 0;
        logic last;
        irq_rise_en_i = '0;
        irq_fall_en_i = '0;
        @(negedge clk);
        last = pwm_o[0];
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            pulses += $countones(irq_rise_o) + $countones(irq_fall_o);
            if (pwm_o[0] != last) tog++;
            last = pwm_o[0];
        end
        chk("R11 disabled irq silent", pulses, 0);
        chk("R11 output still toggles", int'(tog > 0), 1);
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; once_i = 1'b0; slave_i = 1'b0;
        prescale_i = '0; period_i = '0; rise_i = '0; fall_i = '0;
        xfer_req_i = 1'b0; sync_in_i = 1'b0; trans_en_in_i = 1'b0;
        irq_rise_en_i = '0; irq_fall_en_i = '0;
        t_reset();
        t_continuous();
        t_shadow();
        t_prescale();
        t_once();
        t_slave();
        t_irq_off();
        finish_run();
    end

endmodule